// File: doc/BRIEF.md
# Asynchronous Multiplexed Bus Cycle Generator

This block connects a simple internal request port to an external 16-bit asynchronous bus whose address and data share one set of pins. It turns each accepted read or write request into a single bus cycle. During that cycle it drives chip select, address valid, write enable, output enable and the shared lines. Every control edge sits at a programmed tick offset from the start of the cycle, where one tick is one clock. A read captures the bus at its access tick and returns the word to the host with a one-clock done pulse.

An active-low wait input is sampled at the access tick of both reads and writes. While it is low, the cycle freezes. An optional timeout can abort a cycle that stays stalled. The timing inputs are checked against ordering rules at all times, and while they break any rule no cycle may start. After every cycle the block inserts one tick with all controls high before the next cycle.

Top module: `bmx_async_bus`

## Requirements
- R1: After reset, all four controls are high, `bus_ad_en` is 0, `rsp_done` is 0, `to_err` is 0, and `req_ready` is 1 when the configuration is legal.
- R2: A write that starts at tick 0 drives the controls as follows: `bus_cs_n` is low for ticks below `cfg_cs_wr_off`; `bus_adv_n` is low for ticks below `cfg_adv_off`; `bus_we_n` is low from `cfg_we_on` up to but not including `cfg_we_off`; `bus_oe_n` stays high. The bus is driven on every tick, with the address before `cfg_wr_data_on` and the write word from that tick on.
- R3: A read drives the controls as follows: `bus_cs_n` is low below `cfg_cs_rd_off`; `bus_adv_n` is low below `cfg_adv_off`; `bus_oe_n` is low in the range [`cfg_oe_on`, `cfg_oe_off`); `bus_we_n` stays high. The address is driven only while address valid is low, and the bus is released for the rest of the cycle.
- R4: A read captures `bus_ad_i` on the clock edge that ends tick `cfg_rd_access`. The captured word appears on `rsp_rdata` together with a `rsp_done` pulse that lasts exactly one clock.
- R5: A cycle's last tick is its cycle time minus one. It is followed by exactly one gap tick in which all controls are high, the bus is released and `rsp_done` is 1. With a request held valid, the next cycle's tick 0 comes cycle time plus one clocks after the previous tick 0.
- R6: `bus_wait_n` low at the access tick (`cfg_wr_access` for writes, `cfg_rd_access` for reads) holds the tick and every output for each clock it stays low. `bus_wait_n` low at any other tick has no effect.
- R7: `cfg_err` is 1, `req_ready` is 0 and no cycle starts while any of these rules is broken:
  - `cfg_we_off` ≥ `cfg_wr_access`+1;
  - `cfg_cs_wr_off` ≥ `cfg_wr_access`+1;
  - both cycle times are strictly greater than every off time (chip select write and read, address valid, write enable, output enable);
  - each access tick is below its cycle time.
- R8: With `cfg_to_en`=1, a cycle stalled for `TO_PRELOAD`+1 consecutive clocks is aborted. The abort enters the gap tick with a done pulse, sets the sticky `to_err` and loads the cycle address into `to_addr`.
- R9: With `cfg_to_en`=0, a stall lasts as long as `bus_wait_n` stays low, and no done pulse is produced during it.
- R10: Whenever no cycle is active, `bus_ad_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | DW | Address word for the cycle |
| req_wdata | input | DW | Write word |
| rsp_done | output | 1 | One-clock pulse at cycle end |
| rsp_rdata | output | DW | Last captured read word |
| cfg_cs_wr_off | input | TW | Chip select off tick, writes |
| cfg_cs_rd_off | input | TW | Chip select off tick, reads |
| cfg_adv_off | input | TW | Address valid off tick |
| cfg_we_on | input | TW | Write enable on tick |
| cfg_we_off | input | TW | Write enable off tick |
| cfg_oe_on | input | TW | Output enable on tick |
| cfg_oe_off | input | TW | Output enable off tick |
| cfg_wr_data_on | input | TW | Tick where write word replaces address |
| cfg_wr_access | input | TW | Write access (wait sample) tick |
| cfg_rd_access | input | TW | Read access (capture, wait sample) tick |
| cfg_wr_cycle | input | TW | Write cycle length in ticks |
| cfg_rd_cycle | input | TW | Read cycle length in ticks |
| cfg_to_en | input | 1 | Timeout enable |
| cfg_err | output | 1 | Timing rule violation |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_adv_n | output | 1 | Address valid, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_ad_o | output | DW | Shared lines, outgoing value |
| bus_ad_en | output | 1 | Drive enable for the shared lines |
| bus_ad_i | input | DW | Shared lines, incoming value |
| bus_wait_n | input | 1 | Wait, active low |
| to_err | output | 1 | Sticky timeout flag |
| to_addr | output | DW | Address of the aborted cycle |

## Verification
The assertions assume the timing inputs never change while a cycle is in progress. The stimulus honours this by reprogramming them only while the block is idle or held in reset. They also assume that `bus_wait_n` is a clean synchronous level. The bench therefore moves wait and all other inputs only at falling edges, a half clock away from the sampling edge. Stall and timeout windows are counted in clocks by the bench, so an off-by-one in the hold or abort point shows up as a wrong sample tick.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACT  = 2'd1,
      ST_GAP  = 2'd2
   } bmx_state_e;
endpackage

// File: rtl/bmx_cfg_check.sv
module bmx_cfg_check #(
   parameter int TW = 5
) (
   input  logic [TW-1:0] cs_wr_off,
   input  logic [TW-1:0] cs_rd_off,
   input  logic [TW-1:0] adv_off,
   input  logic [TW-1:0] we_off,
   input  logic [TW-1:0] oe_off,
   input  logic [TW-1:0] wr_access,
   input  logic [TW-1:0] rd_access,
   input  logic [TW-1:0] wr_cycle,
   input  logic [TW-1:0] rd_cycle,
   output logic          cfg_err
);
   localparam int NOFF = 5;

   logic [TW-1:0] offs [NOFF];
   logic [TW:0]   wr_acc_p1;

   assign offs[0]   = cs_wr_off;
   assign offs[1]   = cs_rd_off;
   assign offs[2]   = adv_off;
   assign offs[3]   = we_off;
   assign offs[4]   = oe_off;
   assign wr_acc_p1 = {1'b0, wr_access} + (TW+1)'(1);

   always_comb begin
      cfg_err = 1'b0;
      // every off edge must land strictly inside both cycle lengths
      for (int i = 0; i < NOFF; i++) begin
         if (offs[i] >= wr_cycle || offs[i] >= rd_cycle) cfg_err = 1'b1;
      end
      // strobe and select must outlive the write access tick
      if ({1'b0, we_off} < wr_acc_p1)    cfg_err = 1'b1;
      if ({1'b0, cs_wr_off} < wr_acc_p1) cfg_err = 1'b1;
      // access ticks must exist inside their cycles
      if (wr_access >= wr_cycle || rd_access >= rd_cycle) cfg_err = 1'b1;
   end
endmodule

// File: rtl/bmx_tick_seq.sv
module bmx_tick_seq
   import bmx_pkg::*;
#(
   parameter int TW          = 5,
   parameter int DW          = 16,
   parameter bit HAS_TIMEOUT = 1'b1,
   parameter int TO_PRELOAD  = 511
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [DW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          cfg_err,
   input  logic [TW-1:0] wr_cycle,
   input  logic [TW-1:0] rd_cycle,
   input  logic [TW-1:0] wr_access,
   input  logic [TW-1:0] rd_access,
   input  logic          to_en,
   input  logic          wait_n,
   input  logic [DW-1:0] ad_i,
   output logic          act,
   output logic          cyc_wr,
   output logic [TW-1:0] cnt,
   output logic [DW-1:0] cyc_addr,
   output logic [DW-1:0] cyc_wdata,
   output logic          rsp_done,
   output logic [DW-1:0] rsp_rdata,
   output logic          to_err,
   output logic [DW-1:0] to_addr
);
   localparam int TOW = $clog2(TO_PRELOAD + 1);

   bmx_state_e    state;
   logic [TW-1:0] acc_tick;
   logic [TW-1:0] last_tick;
   logic          stall;
   logic          abort;

   assign act       = (state == ST_ACT);
   assign req_ready = (state != ST_ACT) && !cfg_err;
   assign acc_tick  = cyc_wr ? wr_access : rd_access;
   assign last_tick = (cyc_wr ? wr_cycle : rd_cycle) - TW'(1);
   assign stall     = act && (cnt == acc_tick) && !wait_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         cyc_wr    <= 1'b0;
         cyc_addr  <= '0;
         cyc_wdata <= '0;
         rsp_done  <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_done <= 1'b0;
         case (state)
            ST_ACT: begin
               if (abort) begin
                  state    <= ST_GAP;
                  rsp_done <= 1'b1;
               end else if (!stall) begin
                  if (!cyc_wr && cnt == rd_access) rsp_rdata <= ad_i;
                  if (cnt == last_tick) begin
                     state    <= ST_GAP;
                     rsp_done <= 1'b1;
                  end else begin
                     cnt <= cnt + TW'(1);
                  end
               end
            end
            default: begin
               if (req_valid && req_ready) begin
                  state     <= ST_ACT;
                  cnt       <= '0;
                  cyc_wr    <= req_write;
                  cyc_addr  <= req_addr;
                  cyc_wdata <= req_wdata;
               end else begin
                  state <= ST_IDLE;
               end
            end
         endcase
      end
   end

   generate
      if (HAS_TIMEOUT) begin : g_to
         logic [TOW-1:0] to_cnt;
         logic           to_flag;
         logic [DW-1:0]  to_adr;
         assign abort   = stall && to_en && (to_cnt == '0);
         assign to_err  = to_flag;
         assign to_addr = to_adr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               to_cnt  <= TOW'(TO_PRELOAD);
               to_flag <= 1'b0;
               to_adr  <= '0;
            end else begin
               if (!stall)               to_cnt <= TOW'(TO_PRELOAD);
               else if (to_cnt != '0)    to_cnt <= to_cnt - TOW'(1);
               if (abort) begin
                  to_flag <= 1'b1;
                  to_adr  <= cyc_addr;
               end
            end
         end
      end else begin : g_no_to
         assign abort   = 1'b0;
         assign to_err  = 1'b0;
         assign to_addr = '0;
      end
   endgenerate

   // R6: a stall at the access tick freezes the tick counter
   a_r6_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !abort) |=> $stable(cnt) && act);

   // R7: an illegal configuration never lets a cycle begin
   a_r7_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!act && cfg_err) |=> !act);
endmodule

// File: rtl/bmx_pin_drv.sv
module bmx_pin_drv #(
   parameter int TW = 5,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act,
   input  logic          cyc_wr,
   input  logic [TW-1:0] cnt,
   input  logic [DW-1:0] cyc_addr,
   input  logic [DW-1:0] cyc_wdata,
   input  logic [TW-1:0] cs_wr_off,
   input  logic [TW-1:0] cs_rd_off,
   input  logic [TW-1:0] adv_off,
   input  logic [TW-1:0] we_on,
   input  logic [TW-1:0] we_off,
   input  logic [TW-1:0] oe_on,
   input  logic [TW-1:0] oe_off,
   input  logic [TW-1:0] wr_data_on,
   output logic          cs_n,
   output logic          adv_n,
   output logic          we_n,
   output logic          oe_n,
   output logic [DW-1:0] ad_o,
   output logic          ad_en
);
   logic [TW-1:0] cs_off;
   logic          adv_win;

   assign cs_off  = cyc_wr ? cs_wr_off : cs_rd_off;
   assign adv_win = cnt < adv_off;

   always_comb begin
      cs_n  = !(act && cnt < cs_off);
      adv_n = !(act && adv_win);
      we_n  = !(act && cyc_wr && cnt >= we_on && cnt < we_off);
      oe_n  = !(act && !cyc_wr && cnt >= oe_on && cnt < oe_off);
      ad_en = act && (cyc_wr || adv_win);
      if (!act)                            ad_o = '0;
      else if (cyc_wr && cnt >= wr_data_on) ad_o = cyc_wdata;
      else                                  ad_o = cyc_addr;
   end

   // R2: the write strobe only ever belongs to a write cycle
   a_r2_we_write_only: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> cyc_wr);

   // R3: the read strobe only ever belongs to a read cycle
   a_r3_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> !cyc_wr);
endmodule

// File: rtl/bmx_async_bus.sv
module bmx_async_bus #(
   parameter int TW          = 5,
   parameter int DW          = 16,
   parameter bit HAS_TIMEOUT = 1'b1,
   parameter int TO_PRELOAD  = 511
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [DW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_done,
   output logic [DW-1:0] rsp_rdata,
   input  logic [TW-1:0] cfg_cs_wr_off,
   input  logic [TW-1:0] cfg_cs_rd_off,
   input  logic [TW-1:0] cfg_adv_off,
   input  logic [TW-1:0] cfg_we_on,
   input  logic [TW-1:0] cfg_we_off,
   input  logic [TW-1:0] cfg_oe_on,
   input  logic [TW-1:0] cfg_oe_off,
   input  logic [TW-1:0] cfg_wr_data_on,
   input  logic [TW-1:0] cfg_wr_access,
   input  logic [TW-1:0] cfg_rd_access,
   input  logic [TW-1:0] cfg_wr_cycle,
   input  logic [TW-1:0] cfg_rd_cycle,
   input  logic          cfg_to_en,
   output logic          cfg_err,
   output logic          bus_cs_n,
   output logic          bus_adv_n,
   output logic          bus_we_n,
   output logic          bus_oe_n,
   output logic [DW-1:0] bus_ad_o,
   output logic          bus_ad_en,
   input  logic [DW-1:0] bus_ad_i,
   input  logic          bus_wait_n,
   output logic          to_err,
   output logic [DW-1:0] to_addr
);
   generate
      if (TW < 2 || TW > 8) begin : g_bad_tw
         $error("bmx_async_bus: TW out of range");
      end
      if (DW < 8) begin : g_bad_dw
         $error("bmx_async_bus: DW too small");
      end
      if (HAS_TIMEOUT && TO_PRELOAD < 1) begin : g_bad_to
         $error("bmx_async_bus: TO_PRELOAD must be positive");
      end
   endgenerate

   logic          act;
   logic          cyc_wr;
   logic [TW-1:0] cnt;
   logic [DW-1:0] cyc_addr;
   logic [DW-1:0] cyc_wdata;

   bmx_cfg_check #(.TW(TW)) u_chk (
      .cs_wr_off (cfg_cs_wr_off),
      .cs_rd_off (cfg_cs_rd_off),
      .adv_off   (cfg_adv_off),
      .we_off    (cfg_we_off),
      .oe_off    (cfg_oe_off),
      .wr_access (cfg_wr_access),
      .rd_access (cfg_rd_access),
      .wr_cycle  (cfg_wr_cycle),
      .rd_cycle  (cfg_rd_cycle),
      .cfg_err   (cfg_err)
   );

   bmx_tick_seq #(
      .TW(TW), .DW(DW), .HAS_TIMEOUT(HAS_TIMEOUT), .TO_PRELOAD(TO_PRELOAD)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .cfg_err   (cfg_err),
      .wr_cycle  (cfg_wr_cycle),
      .rd_cycle  (cfg_rd_cycle),
      .wr_access (cfg_wr_access),
      .rd_access (cfg_rd_access),
      .to_en     (cfg_to_en),
      .wait_n    (bus_wait_n),
      .ad_i      (bus_ad_i),
      .act       (act),
      .cyc_wr    (cyc_wr),
      .cnt       (cnt),
      .cyc_addr  (cyc_addr),
      .cyc_wdata (cyc_wdata),
      .rsp_done  (rsp_done),
      .rsp_rdata (rsp_rdata),
      .to_err    (to_err),
      .to_addr   (to_addr)
   );

   bmx_pin_drv #(.TW(TW), .DW(DW)) u_drv (
      .clk        (clk),
      .rst_n      (rst_n),
      .act        (act),
      .cyc_wr     (cyc_wr),
      .cnt        (cnt),
      .cyc_addr   (cyc_addr),
      .cyc_wdata  (cyc_wdata),
      .cs_wr_off  (cfg_cs_wr_off),
      .cs_rd_off  (cfg_cs_rd_off),
      .adv_off    (cfg_adv_off),
      .we_on      (cfg_we_on),
      .we_off     (cfg_we_off),
      .oe_on      (cfg_oe_on),
      .oe_off     (cfg_oe_off),
      .wr_data_on (cfg_wr_data_on),
      .cs_n       (bus_cs_n),
      .adv_n      (bus_adv_n),
      .we_n       (bus_we_n),
      .oe_n       (bus_oe_n),
      .ad_o       (bus_ad_o),
      .ad_en      (bus_ad_en)
   );

   // R4: the completion strobe is a single clock wide
   a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R5, R10: a free request port means the bus is quiet and released
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (bus_cs_n && bus_we_n && bus_oe_n && !bus_ad_en));

   // R7: a flagged configuration closes the request port
   a_r7_port_closed: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !req_ready);
endmodule

// File: tb/bmx_async_bus_test.sv
`timescale 1ns/1ps
module bmx_async_bus_test;
   localparam int TW = 5;
   localparam int DW = 16;
   localparam int PRE = 511;
   localparam int NVEC = 6;
   // {write, addr, word, stall clocks}
   localparam logic [36:0] VEC [NVEC] = '{
      {1'b1, 16'h1234, 16'hABCD, 4'd0},
      {1'b0, 16'h0042, 16'h5A5A, 4'd0},
      {1'b1, 16'hFFFF, 16'h0000, 4'd3},
      {1'b0, 16'h8001, 16'hC3C3, 4'd2},
      {1'b1, 16'h0000, 16'hFFFF, 4'd1},
      {1'b0, 16'h7FFE, 16'h0001, 4'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [DW-1:0] req_addr = '0, req_wdata = '0, bus_ad_i = '0;
   logic bus_wait_n = 1'b1, cfg_to_en = 1'b0;
   logic [TW-1:0] c_cswr, c_csrd, c_adv, c_weon, c_weoff, c_oeon, c_oeoff;
   logic [TW-1:0] c_don, c_wacc, c_racc, c_wcyc, c_rcyc;
   logic req_ready, rsp_done, cfg_err, to_err;
   logic bus_cs_n, bus_adv_n, bus_we_n, bus_oe_n, bus_ad_en;
   logic [DW-1:0] rsp_rdata, bus_ad_o, to_addr;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   bmx_async_bus #(.TW(TW), .DW(DW), .HAS_TIMEOUT(1'b1), .TO_PRELOAD(PRE)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .cfg_cs_wr_off(c_cswr), .cfg_cs_rd_off(c_csrd), .cfg_adv_off(c_adv),
      .cfg_we_on(c_weon), .cfg_we_off(c_weoff), .cfg_oe_on(c_oeon),
      .cfg_oe_off(c_oeoff), .cfg_wr_data_on(c_don), .cfg_wr_access(c_wacc),
      .cfg_rd_access(c_racc), .cfg_wr_cycle(c_wcyc), .cfg_rd_cycle(c_rcyc),
      .cfg_to_en(cfg_to_en), .cfg_err(cfg_err),
      .bus_cs_n(bus_cs_n), .bus_adv_n(bus_adv_n), .bus_we_n(bus_we_n),
      .bus_oe_n(bus_oe_n), .bus_ad_o(bus_ad_o), .bus_ad_en(bus_ad_en),
      .bus_ad_i(bus_ad_i), .bus_wait_n(bus_wait_n),
      .to_err(to_err), .to_addr(to_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic good_cfg();
      c_cswr = 9; c_csrd = 8; c_adv = 1; c_weon = 2; c_weoff = 8;
      c_oeon = 1; c_oeoff = 8; c_don = 2; c_wacc = 7; c_racc = 8;
      c_wcyc = 10; c_rcyc = 10;
   endtask

   function automatic logic [20:0] pins_now();
      return {bus_cs_n, bus_adv_n, bus_we_n, bus_oe_n, bus_ad_en,
              bus_ad_en ? bus_ad_o : 16'h0};
   endfunction

   function automatic logic [20:0] pins_exp(bit wr, int t, logic [15:0] a, logic [15:0] d);
      logic cs, adv, we, oe, en;
      cs  = !(t < int'(wr ? c_cswr : c_csrd));
      adv = !(t < int'(c_adv));
      we  = !(wr && t >= int'(c_weon) && t < int'(c_weoff));
      oe  = !(!wr && t >= int'(c_oeon) && t < int'(c_oeoff));
      en  = wr || (t < int'(c_adv));
      return {cs, adv, we, oe, en, en ? ((wr && t >= int'(c_don)) ? d : a) : 16'h0};
   endfunction

   // issues a request at a falling edge; returns at the falling edge showing tick 0
   task automatic start(input bit wr, input logic [15:0] a, input logic [15:0] d);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic run_cycle(input bit wr, input logic [15:0] a, input logic [15:0] d,
                            input int stall_k, input int early_tick);
      int cyc, acc;
      cyc = wr ? int'(c_wcyc) : int'(c_rcyc);
      acc = wr ? int'(c_wacc) : int'(c_racc);
      start(wr, a, wr ? d : 16'h0);
      for (int t = 0; t < cyc; t++) begin
         chk(wr ? "R2 write tick" : "R3 read tick", 32'(pins_now()), 32'(pins_exp(wr, t, a, d)));
         bus_ad_i = (t == int'(c_racc)) ? d : ~d;
         if (t == acc && stall_k > 0) begin
            bus_wait_n = 1'b0;
            for (int i = 0; i < stall_k; i++) begin
               @(negedge clk);
               chk("R6 held during wait", 32'(pins_now()), 32'(pins_exp(wr, t, a, d)));
            end
         end
         if (t == early_tick) bus_wait_n = 1'b0;
         else                 bus_wait_n = 1'b1;
         if (t == early_tick) begin
            @(negedge clk);
            bus_wait_n = 1'b1;
            if (t + 1 < cyc)
               chk("R6 wait off access tick ignored", 32'(pins_now()), 32'(pins_exp(wr, t + 1, a, d)));
            t++;
            bus_ad_i = (t == int'(c_racc)) ? d : ~d;
            if (t >= cyc) break;
         end
         @(negedge clk);
      end
      chk("R5 gap tick quiet", 32'(pins_now()), {11'h0, 21'h1E0000});
      chk("R4 done in gap", 32'(rsp_done), 32'd1);
      if (!wr) chk("R4 captured word", 32'(rsp_rdata), 32'(d));
      @(negedge clk);
      chk("R4 done single clock", 32'(rsp_done), 32'd0);
      chk("R10 bus released when idle", 32'(bus_ad_en), 32'd0);
   endtask

   initial begin
      int n;
      bit seen;
      // document timing set: write off edges equal to the access tick
      good_cfg();
      c_cswr = 7; c_weoff = 7; c_wcyc = 9;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7 rule flagged", 32'(cfg_err), 32'd1);
      chk("R7 port closed", 32'(req_ready), 32'd0);
      req_valid = 1'b1; req_write = 1'b1;
      n = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (!bus_cs_n) n++;
      end
      req_valid = 1'b0;
      chk("R7 no cycle started", 32'(n), 32'd0);
      good_cfg(); c_wcyc = 9;                 // cs_wr_off 9 not below cycle 9
      #1 chk("R7 cycle not above off", 32'(cfg_err), 32'd1);
      good_cfg(); c_racc = 10;                // access at cycle length
      #1 chk("R7 access outside cycle", 32'(cfg_err), 32'd1);
      good_cfg();
      #1 chk("R7 legal set clear", 32'(cfg_err), 32'd0);

      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset pins", 32'(pins_now()), {11'h0, 21'h1E0000});
      chk("R1 reset done", 32'(rsp_done), 32'd0);
      chk("R1 reset ready", 32'(req_ready), 32'd1);
      chk("R1 reset timeout flag", 32'(to_err), 32'd0);

      for (int v = 0; v < NVEC; v++)
         run_cycle(VEC[v][36], VEC[v][35:20], VEC[v][19:4], int'(VEC[v][3:0]), -1);

      // R6: wait low at tick 3 of a write has no effect
      run_cycle(1'b1, 16'h2468, 16'h1357, 0, 3);

      // R5: held request, tick 0 to tick 0 spacing is cycle + 1
      req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0101; req_wdata = 16'h0202;
      @(negedge clk);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (bus_adv_n && n < 40);
      req_valid = 1'b0;
      chk("R5 back to back spacing", 32'(n), 32'(c_wcyc) + 32'd1);
      repeat (14) @(negedge clk);

      // R9: timeout disabled, long stall
      cfg_to_en = 1'b0;
      start(1'b1, 16'h0BAD, 16'h0FAD);
      repeat (int'(c_wacc)) @(negedge clk);
      bus_wait_n = 1'b0;
      seen = 1'b0;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (rsp_done) seen = 1'b1;
      end
      chk("R9 no done while stalled", 32'(seen), 32'd0);
      chk("R9 still at access tick", 32'(pins_now()), 32'(pins_exp(1'b1, int'(c_wacc), 16'h0BAD, 16'h0FAD)));
      chk("R9 no timeout flag", 32'(to_err), 32'd0);
      bus_wait_n = 1'b1;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!rsp_done && n < 40);
      chk("R9 completes after release", 32'(n), 32'(c_wcyc) - 32'(c_wacc));
      @(negedge clk);

      // R8: timeout enabled, read stalled at its access tick
      cfg_to_en = 1'b1;
      start(1'b0, 16'h4321, 16'h0);
      repeat (int'(c_racc)) @(negedge clk);
      bus_wait_n = 1'b0;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!rsp_done && n < 1000);
      chk("R8 abort after preload+1", 32'(n), 32'(PRE + 1));
      chk("R8 gap after abort", 32'(pins_now()), {11'h0, 21'h1E0000});
      chk("R8 flag set", 32'(to_err), 32'd1);
      chk("R8 address latched", 32'(to_addr), 32'h4321);
      bus_wait_n = 1'b1;
      @(negedge clk);
      chk("R10 released after abort", 32'(bus_ad_en), 32'd0);
      chk("R8 flag sticky", 32'(to_err), 32'd1);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule